// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block sits on the device side of a three-wire configuration link made of a serial clock, a serial data line and a latch strobe. A host shifts 32-bit words in, most-significant bit first, one bit per rising serial-clock edge, while the strobe is low. When the strobe then rises, the low four bits of the word select one of sixteen registers and the upper 28 bits are stored there. Other logic reads any register through a combinational read port.

All three link lines are brought into the system clock domain through two-flop synchronizers, and their edges are detected there. The system clock must run at least four times faster than the serial clock. A word whose strobe arrives after any bit count other than 32 is dropped and flagged. A reset bit in one register returns the whole file to its defaults. Writing the highest register fires a one-cycle calibration-start pulse and holds a busy flag for a fixed window.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, register i (0..15) reads (i << 16) | (i << 4), and frame_err, cal_start and cal_busy are low.
- R2: A word is shifted in most-significant first. When the strobe rises after exactly 32 serial-clock rising edges, word bits 3..0 select the register and word bits 31..4 are stored as its 28-bit value.
- R3: When the strobe rises after a bit count other than 32, no register changes and frame_err goes high. It stays high until the next valid commit clears it.
- R4: A valid word to register 7 with word bit 4 (data bit 0) set returns all sixteen registers to their R1 defaults. The other bits of that word are ignored, so register 7 also reads its default.
- R5: A valid word to register 7 with word bit 4 clear stores its data like any other register.
- R6: Each valid write to register 15 produces a cal_start pulse exactly one system cycle wide, and every rewrite produces another one. Writes to other registers produce none.
- R7: cal_busy is high for exactly 64 consecutive system cycles, starting in the cycle of the cal_start pulse.
- R8: A one-cycle synchronous srst returns all registers to their defaults, clears frame_err and discards any partly shifted bits. A full word sent afterwards commits normally.
- R9: Serial-clock edges while the strobe is high are not counted. A valid word that follows them commits without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| srst | input | 1 | Synchronous reset to defaults |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe, low while shifting, rising edge commits |
| rd_addr | input | 4 | Read register index |
| rd_data | output | 28 | Contents of the selected register |
| frame_err | output | 1 | Last strobe arrived after a bit count other than 32 |
| cal_start | output | 1 | One-cycle calibration-start pulse |
| cal_busy | output | 1 | High during the 64-cycle calibration window |

## Verification
A wrong bit counter has two visible effects. A valid word can raise frame_err, or it can land at a shifted address. Either shows up at the read port within a few system cycles of the strobe edge. A fault in the shift path or the address decode corrupts one register value, or changes a register that should have kept its value. The scoreboard catches this at the next read-back. A fault in the soft-reset or calibration logic changes the whole register file, the cal_start width or the length of the busy window, and these are measured cycle by cycle at the ports.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = WORD_W - ADDR_W;
  localparam int NREG    = 1 << ADDR_W;
  localparam int RST_REG = 7;
  localparam int RST_BIT = 0;
  localparam int CAL_REG = NREG - 1;
  localparam int CAL_CYC = 64;

  // Default contents: index placed in two nibble lanes.
  function automatic logic [DATA_W-1:0] reg_default(input int unsigned idx);
    logic [DATA_W-1:0] v;
    v = DATA_W'(idx);
    return (v << 16) | (v << 4);
  endfunction
endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cfgrx_frame.sv
module cfgrx_frame
  import cfgrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              le_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_err
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_SAT = WORD_W + 1;

  logic              sclk_q, le_q;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic              wr_q, wr_d;
  logic              sclk_rise, le_rise;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign le_rise   = le_s & ~le_q;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    wr_d    = 1'b0;
    if (srst) begin
      cnt_d = '0;
      err_d = 1'b0;
    end else if (le_rise) begin
      cnt_d = '0;
      if (cnt_q == CNT_W'(WORD_W)) begin
        wr_d  = 1'b1;
        err_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end else if (sclk_rise && !le_s) begin
      shift_d = {shift_q[WORD_W-2:0], sdat_s};
      if (cnt_q != CNT_W'(CNT_SAT)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      le_q    <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      sclk_q  <= sclk_s;
      le_q    <= le_s;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      wr_q    <= wr_d;
    end
  end

  assign wr_en     = wr_q;
  assign wr_addr   = shift_q[ADDR_W-1:0];
  assign wr_data   = shift_q[WORD_W-1:ADDR_W];
  assign frame_err = err_q;

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_SAT));
  p_err_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(le_rise));
  p_err_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> !err_q);
endmodule

// File: rtl/cfgrx_regfile.sv
module cfgrx_regfile
  import cfgrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] regs_d [NREG];
  logic              soft_rst;

  assign soft_rst = wr_en && (wr_addr == ADDR_W'(RST_REG)) && wr_data[RST_BIT];

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    if (srst || soft_rst) begin
      for (int i = 0; i < NREG; i++) regs_d[i] = reg_default(i);
    end else if (wr_en) begin
      regs_d[wr_addr] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= reg_default(i);
    end else begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rd_data = regs_q[rd_addr];

  p_softrst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(RST_REG) && wr_data[RST_BIT])
      |=> (regs_q[RST_REG] == reg_default(RST_REG) && regs_q[0] == reg_default(0)));
  p_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (regs_q[NREG-1] == reg_default(NREG-1)));
endmodule

// File: rtl/cfgrx_caltimer.sv
module cfgrx_caltimer
  import cfgrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic trig,
  output logic cal_start,
  output logic cal_busy
);
  localparam int TW = $clog2(CAL_CYC + 1);

  logic [TW-1:0] tmr_q, tmr_d;
  logic          start_q, start_d;

  always_comb begin
    start_d = 1'b0;
    tmr_d   = tmr_q;
    if (srst) begin
      tmr_d = '0;
    end else if (trig) begin
      start_d = 1'b1;
      tmr_d   = TW'(CAL_CYC);
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      start_q <= 1'b0;
    end else begin
      tmr_q   <= tmr_d;
      start_q <= start_d;
    end
  end

  assign cal_start = start_q;
  assign cal_busy  = (tmr_q != '0);

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  p_busy_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> cal_busy);
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !srst && tmr_q != TW'(1)) |=> cal_busy);
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfgrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              frame_err,
  output logic              cal_start,
  output logic              cal_busy
);
  logic              rst_meta_q, rst_sync_q;
  logic [2:0]        pins_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              cal_trig;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfgrx_sync #(.N(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .din   ({ser_le, ser_dat, ser_clk}),
    .dout  (pins_s)
  );

  cfgrx_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .srst      (srst),
    .sclk_s    (pins_s[0]),
    .sdat_s    (pins_s[1]),
    .le_s      (pins_s[2]),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_err (frame_err)
  );

  cfgrx_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .srst    (srst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign cal_trig = wr_en && (wr_addr == ADDR_W'(CAL_REG));

  cfgrx_caltimer u_cal (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .srst      (srst),
    .trig      (cal_trig),
    .cal_start (cal_start),
    .cal_busy  (cal_busy)
  );
endmodule

// File: tb/cfg_serial_rx_test.sv
module cfg_serial_rx_test;
  localparam time PERIOD = 10ns;
  localparam int  HALF   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        srst = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_le = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [27:0] rd_data;
  logic        frame_err, cal_start, cal_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0]  a;
    logic [27:0] d;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic [27:0] model [16];

  int pulses = 0, cur_w = 0, last_w = 0, max_w = 0;
  int busy_run = 0, last_busy = 0;

  always #(PERIOD/2) clk = ~clk;

  cfg_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_err(frame_err), .cal_start(cal_start), .cal_busy(cal_busy)
  );

  // Calibration monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (cal_start) begin
      cur_w++;
    end else if (cur_w != 0) begin
      pulses++;
      last_w = cur_w;
      if (cur_w > max_w) max_w = cur_w;
      cur_w = 0;
    end
    if (cal_busy) busy_run++;
    else if (busy_run != 0) begin
      last_busy = busy_run;
      busy_run = 0;
    end
  end

  function automatic logic [27:0] dflt(input int i);
    return (28'(i) << 16) | (28'(i) << 4);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int a, input string tag);
    item_t it;
    it.a = 4'(a); it.d = model[a]; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic push_all(input string tag);
    for (int i = 0; i < 16; i++) push(i, tag);
  endtask

  // Scoreboard monitor: pop expectations and compare against the read port.
  task automatic drain();
    while (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      @(negedge clk);
      rd_addr = it.a;
      #1;
      check(rd_data == it.d, it.tag, rd_data, it.d);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int nbits);
    for (int i = 31; i > 31 - nbits; i--) begin
      ser_dat = w[i];
      wait_cyc(HALF);
      ser_clk = 1'b1;
      wait_cyc(HALF);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe(input int extra_clks);
    wait_cyc(HALF);
    ser_le = 1'b1;
    for (int k = 0; k < extra_clks; k++) begin
      wait_cyc(HALF);
      ser_clk = 1'b1;
      wait_cyc(HALF);
      ser_clk = 1'b0;
    end
    wait_cyc(HALF);
    ser_le = 1'b0;
    wait_cyc(8);
  endtask

  task automatic send(input int a, input logic [27:0] d, input int nbits, input int extra);
    shift_bits({d, 4'(a)}, nbits);
    strobe(extra);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int p0;
    for (int i = 0; i < 16; i++) model[i] = dflt(i);
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    check(!frame_err, "R1 frame_err", frame_err, 0);
    check(!cal_start, "R1 cal_start", cal_start, 0);
    check(!cal_busy,  "R1 cal_busy",  cal_busy, 0);
    push_all("R1 default");
    drain();

    // R2 plain writes, several patterns
    send(3, 28'hABCDEF1, 32, 0);  model[3]  = 28'hABCDEF1;  push(3, "R2 reg3");
    send(0, 28'hFFFFFFF, 32, 0);  model[0]  = 28'hFFFFFFF;  push(0, "R2 reg0");
    send(14, 28'h0000001, 32, 0); model[14] = 28'h0000001; push(14, "R2 reg14");
    send(9, 28'h8000000, 32, 0);  model[9]  = 28'h8000000;  push(9, "R2 reg9");
    push(4, "R2 untouched reg4");
    drain();
    check(!frame_err, "R2 no error", frame_err, 0);

    // R3 short and long frames
    send(5, 28'h5555555, 20, 0);
    check(frame_err, "R3 short frame flag", frame_err, 1);
    push(5, "R3 short frame discarded");
    drain();
    send(6, 28'h6666666, 32, 0);
    check(!frame_err, "R3 flag cleared", frame_err, 0);
    model[6] = 28'h6666666; push(6, "R3 valid after error");
    shift_bits(32'h0, 1);
    send(5, 28'h1234567, 32, 0);
    check(frame_err, "R3 long frame flag", frame_err, 1);
    push(5, "R3 long frame discarded");
    drain();

    // R9 serial clocks while strobe is high
    send(10, 28'hA0A0A0A, 32, 3);
    model[10] = 28'hA0A0A0A;
    check(!frame_err, "R9 commit with extra clocks", frame_err, 0);
    send(11, 28'hB0B0B0B, 32, 0);
    model[11] = 28'hB0B0B0B;
    check(!frame_err, "R9 next word ok", frame_err, 0);
    push(10, "R9 reg10"); push(11, "R9 reg11");
    drain();

    // R5 reg7 normal write
    send(7, 28'h1234560, 32, 0);
    model[7] = 28'h1234560; push(7, "R5 reg7 store");
    drain();

    // R4 soft reset
    send(7, 28'hFFFFFF1, 32, 0);
    for (int i = 0; i < 16; i++) model[i] = dflt(i);
    push_all("R4 soft reset");
    drain();

    // R6 / R7 calibration
    p0 = pulses;
    send(14, 28'h0000022, 32, 0);
    model[14] = 28'h0000022;
    wait_cyc(4);
    check(pulses == p0, "R6 no pulse on reg14", pulses, p0);
    send(15, 28'h00000F0, 32, 0);
    model[15] = 28'h00000F0;
    wait_cyc(80);
    check(pulses == p0 + 1, "R6 pulse on reg15", pulses, p0 + 1);
    check(max_w == 1, "R6 pulse width", max_w, 1);
    check(last_busy == 64, "R7 busy length", last_busy, 64);
    send(15, 28'h00000F1, 32, 0);
    model[15] = 28'h00000F1;
    wait_cyc(80);
    check(pulses == p0 + 2, "R6 rewrite pulse", pulses, p0 + 2);
    check(last_w == 1, "R6 rewrite width", last_w, 1);
    check(last_busy == 64, "R7 busy length rewrite", last_busy, 64);
    push(15, "R6 reg15 stored");
    drain();

    // R8 synchronous reset mid-frame
    send(2, 28'h2222222, 32, 0);
    shift_bits(32'hFFFFFFFF, 10);
    @(negedge clk); srst = 1'b1;
    @(negedge clk); srst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = dflt(i);
    send(9, 28'h9999999, 32, 0);
    model[9] = 28'h9999999;
    check(!frame_err, "R8 word after srst", frame_err, 0);
    push(2, "R8 reg2 default"); push(9, "R8 reg9 new"); push(15, "R8 reg15 default");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule